// File: doc/BRIEF.md
# Flash Program/Erase Controller

This block guards a small on-chip flash array, modelled as a memory of 16-bit halfwords, and carries out page erases and single-halfword programming on behalf of software. A synchronous register bus reaches four registers: an unlock key register, a control register, a status register and a target-address register. A second port, addressed with byte addresses inside a fixed flash window, reads the array and carries the halfword being programmed.

The controller starts out locked. Software must write two fixed 32-bit keys in the right order before the control register accepts anything. A page erase takes three steps: set the erase-enable bit, load the address register, then write the start bit with erase-enable still set. Programming takes one step per halfword: with program-enable set, write the halfword through the array port. Both operations hold the busy flag high for a fixed number of cycles, and each has its own parameter for that count. A program request only lands on a halfword that still holds the erased value. Requests aimed at protected pages, or at addresses outside the window, are refused. Each refusal is reported through a sticky status bit, and software clears that bit by writing 1 to it.

Top module: `nvm_pe_ctrl`

## Requirements
- R1: After reset the control register reads 0x8: the lock bit (bit 3) is set, and program-enable (bit 0) and erase-enable (bit 1) are clear. The status register reads 0, with busy in bit 0, program error in bit 1 and protection error in bit 2.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key register (offset 0) clears the lock bit. The control register then reads 0x0.
- R3: Once any key write breaks that order, the controller stays locked until reset, even if the correct pair is written afterwards.
- R4: While locked, writes to the control register (offset 1) change neither bit 0 nor bit 1, and a start request (bit 2) starts no operation.
- R5: Writing 1 to bit 3 of the control register while unlocked and idle sets the lock bit and clears program-enable and erase-enable. The block then stays locked until a new valid key pair arrives.
- R6: A page erase sets every halfword of the 1 KB page that holds the address register's value (offset 3) to 0xFFFF, wherever in the page that address lies. The erase is started by a control write with bits 1 and 2 set and bit 3 clear. Other pages keep their contents, and busy stays high for exactly ERASE_CYC cycles.
- R7: With program-enable set, an array-port write to an even address in an erased halfword stores the data. Busy stays high for exactly PROG_CYC cycles.
- R8: A program request to a halfword that does not read 0xFFFF leaves the array unchanged and sets status bit 1.
- R9: An erase or program request aimed at a page whose bit is set in wp_mask, or at an address outside the window starting at 0x0800_0000, leaves the array unchanged, sets status bit 2 and does not raise busy.
- R10: A program request to an odd byte address leaves the array unchanged and sets status bit 1.
- R11: Writing 1 to status bit 1 or bit 2 clears that bit. Writing 0 to it leaves it unchanged.
- R12: While busy, control writes (including lock and start) and array-port program requests are ignored.
- R13: An array-port write while program-enable is clear changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 key, 1 control, 2 status, 3 address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; reg_rdata is valid one cycle later |
| reg_rdata | output | 32 | Registered register read data |
| mem_addr | input | 32 | Byte address on the array port |
| mem_wdata | input | 16 | Halfword to program |
| mem_we | input | 1 | Program request strobe |
| mem_rdata | output | 16 | Halfword at mem_addr one cycle earlier; 0 outside the window |
| wp_mask | input | NUM_PAGES | Write protection, one bit per page |

## Verification
Programming is tried on an erased halfword, on the same halfword once it holds data, on an odd address, on a protected page and past the end of the window. These five cases separate a stored write from a program-error refusal and from a protection refusal. The erase is aimed at an address in the middle of a page. Halfwords are then checked at the first and last positions of that page and in the neighbouring pages, which shows whether page alignment and page bounds are right. Key sequences are tried in the correct order, in reversed order followed by the correct order, and again after a relock, so that a stuck-locked controller can be told apart from one that merely needs the keys. Busy length is counted in cycles for both operation types.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam logic [31:0] UNLOCK_KEY_A = 32'h4567_0123;
  localparam logic [31:0] UNLOCK_KEY_B = 32'hCDEF_89AB;

  localparam logic [1:0] RA_KEY  = 2'd0;
  localparam logic [1:0] RA_CTL  = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;
  localparam logic [1:0] RA_ADDR = 2'd3;

  localparam int CTL_PROG  = 0;
  localparam int CTL_ERASE = 1;
  localparam int CTL_START = 2;
  localparam int CTL_LOCK  = 3;

  localparam int ST_BUSY  = 0;
  localparam int ST_PGERR = 1;
  localparam int ST_WPERR = 2;

  localparam logic [15:0] ERASED_HW = 16'hFFFF;

  typedef enum logic [1:0] {KS_WAIT_A, KS_WAIT_B, KS_OPEN, KS_DEAD} key_state_e;
  typedef enum logic [2:0] {SQ_IDLE, SQ_ERASE, SQ_PRD, SQ_PWR, SQ_HOLD} seq_state_e;
endpackage

// File: rtl/nvm_key_unlock.sv
module nvm_key_unlock
  import nvm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        key_we,
  input  logic [31:0] key_data,
  input  logic        relock,
  output logic        locked,
  output logic        dead
);
  key_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= KS_WAIT_A;
    end else begin
      case (state_q)
        KS_WAIT_A: if (key_we) state_q <= (key_data == UNLOCK_KEY_A) ? KS_WAIT_B : KS_DEAD;
        KS_WAIT_B: if (key_we) state_q <= (key_data == UNLOCK_KEY_B) ? KS_OPEN : KS_DEAD;
        KS_OPEN:   if (relock) state_q <= KS_WAIT_A;
        default:   state_q <= KS_DEAD;
      endcase
    end
  end

  always_comb begin
    locked = (state_q != KS_OPEN);
    dead   = (state_q == KS_DEAD);
  end
endmodule

// File: rtl/nvm_array.sv
module nvm_array
  import nvm_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [15:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [15:0]   rdata
);
  logic [15:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = ERASED_HW;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nvm_pe_seq.sv
module nvm_pe_seq
  import nvm_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR  = 32'h0800_0000,
  parameter int          PAGE_BYTES = 1024,
  parameter int          NUM_PAGES  = 4,
  parameter int          ERASE_CYC  = 600,
  parameter int          PROG_CYC   = 6,
  localparam int         PB         = $clog2(PAGE_BYTES),
  localparam int         PWW        = PB - 1,
  localparam int         PGW        = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int         AW         = PGW + PWW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 erase_go,
  input  logic [31:0]          erase_addr,
  input  logic                 prog_go,
  input  logic [31:0]          prog_addr,
  input  logic [15:0]          prog_data,
  input  logic [NUM_PAGES-1:0] wp_mask,
  input  logic [15:0]          arr_rdata,
  output logic                 busy,
  output logic                 arr_we,
  output logic [AW-1:0]        arr_waddr,
  output logic [15:0]          arr_wdata,
  output logic [AW-1:0]        arr_raddr,
  output logic                 rd_own,
  output logic                 set_pg_err,
  output logic                 set_wp_err
);
  localparam int MAXC        = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW          = $clog2(MAXC + 1);
  localparam int TOTAL_BYTES = NUM_PAGES * PAGE_BYTES;

  seq_state_e     state_q;
  logic [CW-1:0]  cnt_q, lim_q;
  logic [PGW-1:0] epage_q;
  logic [PWW-1:0] eidx_q;
  logic [AW-1:0]  widx_q;
  logic [15:0]    wdat_q;

  function automatic logic blocked(input logic [31:0] a, input logic [NUM_PAGES-1:0] m);
    logic [31:0] off;
    off = a - BASE_ADDR;
    if (a < BASE_ADDR || off >= 32'(TOTAL_BYTES)) return 1'b1;
    return m[off[PB +: PGW]];
  endfunction

  logic [31:0] e_off, p_off;
  logic        e_blk, p_blk, p_odd, idle;

  always_comb begin
    e_off = erase_addr - BASE_ADDR;
    p_off = prog_addr - BASE_ADDR;
    e_blk = blocked(erase_addr, wp_mask);
    p_blk = blocked(prog_addr, wp_mask);
    p_odd = prog_addr[0];
    idle  = (state_q == SQ_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      lim_q   <= '0;
      epage_q <= '0;
      eidx_q  <= '0;
      widx_q  <= '0;
      wdat_q  <= '0;
    end else if (idle) begin
      if (erase_go && !e_blk) begin
        state_q <= SQ_ERASE;
        cnt_q   <= CW'(1);
        lim_q   <= CW'(ERASE_CYC);
        epage_q <= e_off[PB +: PGW];
        eidx_q  <= '0;
      end else if (!erase_go && prog_go && !p_odd && !p_blk) begin
        state_q <= SQ_PRD;
        cnt_q   <= CW'(1);
        lim_q   <= CW'(PROG_CYC);
        widx_q  <= p_off[1 +: AW];
        wdat_q  <= prog_data;
      end
    end else if (cnt_q == lim_q) begin
      state_q <= SQ_IDLE;
    end else begin
      cnt_q <= cnt_q + CW'(1);
      case (state_q)
        SQ_ERASE: begin
          eidx_q <= eidx_q + PWW'(1);
          if (eidx_q == {PWW{1'b1}}) state_q <= SQ_HOLD;
        end
        SQ_PRD:  state_q <= SQ_PWR;
        SQ_PWR:  state_q <= SQ_HOLD;
        default: state_q <= state_q;
      endcase
    end
  end

  logic prog_hit_clean;

  always_comb begin
    prog_hit_clean = (state_q == SQ_PWR) && (arr_rdata == ERASED_HW);
    busy       = !idle;
    rd_own     = (state_q == SQ_PRD);
    arr_raddr  = widx_q;
    arr_we     = (state_q == SQ_ERASE) || prog_hit_clean;
    arr_waddr  = (state_q == SQ_ERASE) ? {epage_q, eidx_q} : widx_q;
    arr_wdata  = (state_q == SQ_ERASE) ? ERASED_HW : wdat_q;
    set_pg_err = (idle && !erase_go && prog_go && p_odd) ||
                 ((state_q == SQ_PWR) && (arr_rdata != ERASED_HW));
    set_wp_err = (idle && erase_go && e_blk) ||
                 (idle && !erase_go && prog_go && !p_odd && p_blk);
  end
endmodule

// File: rtl/nvm_pe_ctrl.sv
module nvm_pe_ctrl
  import nvm_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR  = 32'h0800_0000,
  parameter int          PAGE_BYTES = 1024,
  parameter int          NUM_PAGES  = 4,
  parameter int          ERASE_CYC  = 600,
  parameter int          PROG_CYC   = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  input  logic                 reg_we,
  input  logic                 reg_re,
  output logic [31:0]          reg_rdata,
  input  logic [31:0]          mem_addr,
  input  logic [15:0]          mem_wdata,
  input  logic                 mem_we,
  output logic [15:0]          mem_rdata,
  input  logic [NUM_PAGES-1:0] wp_mask
);
  localparam int PB          = $clog2(PAGE_BYTES);
  localparam int PGW         = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam int AW          = PGW + PB - 1;
  localparam int DEPTH       = 1 << AW;
  localparam int TOTAL_BYTES = NUM_PAGES * PAGE_BYTES;

  logic          locked, key_dead, busy;
  logic          prog_en_q, erase_en_q, pg_err_q, wp_err_q, oob_q;
  logic [31:0]   addr_q;
  logic          wr_key, wr_ctl, wr_stat, wr_addr, ctl_ok, relock, erase_go, prog_go;
  logic          arr_we, rd_own, set_pg, set_wp;
  logic [AW-1:0] arr_waddr, seq_raddr, arr_raddr, user_idx;
  logic [15:0]   arr_wdata, arr_rdata;
  logic [31:0]   user_off;
  logic          user_oob;

  always_comb begin
    wr_key   = reg_we && (reg_addr == RA_KEY) && locked;
    wr_ctl   = reg_we && (reg_addr == RA_CTL);
    wr_stat  = reg_we && (reg_addr == RA_STAT);
    wr_addr  = reg_we && (reg_addr == RA_ADDR) && !busy;
    ctl_ok   = wr_ctl && !locked && !busy;
    relock   = ctl_ok && reg_wdata[CTL_LOCK];
    erase_go = ctl_ok && !reg_wdata[CTL_LOCK] && reg_wdata[CTL_START] && reg_wdata[CTL_ERASE];
    prog_go  = mem_we && prog_en_q && !locked && !busy;
    user_off = mem_addr - BASE_ADDR;
    user_oob = (mem_addr < BASE_ADDR) || (user_off >= 32'(TOTAL_BYTES));
    user_idx = user_off[1 +: AW];
    arr_raddr = rd_own ? seq_raddr : user_idx;
  end

  nvm_key_unlock u_key (
    .clk(clk), .rst(rst), .key_we(wr_key), .key_data(reg_wdata),
    .relock(relock), .locked(locked), .dead(key_dead)
  );

  nvm_pe_seq #(
    .BASE_ADDR(BASE_ADDR), .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES),
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk(clk), .rst(rst),
    .erase_go(erase_go), .erase_addr(addr_q),
    .prog_go(prog_go), .prog_addr(mem_addr), .prog_data(mem_wdata),
    .wp_mask(wp_mask), .arr_rdata(arr_rdata),
    .busy(busy), .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
    .arr_raddr(seq_raddr), .rd_own(rd_own),
    .set_pg_err(set_pg), .set_wp_err(set_wp)
  );

  nvm_array #(.DEPTH(DEPTH), .AW(AW)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(arr_raddr), .rdata(arr_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_en_q  <= 1'b0;
      erase_en_q <= 1'b0;
      pg_err_q   <= 1'b0;
      wp_err_q   <= 1'b0;
      addr_q     <= '0;
      oob_q      <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      if (relock) begin
        prog_en_q  <= 1'b0;
        erase_en_q <= 1'b0;
      end else if (ctl_ok) begin
        prog_en_q  <= reg_wdata[CTL_PROG];
        erase_en_q <= reg_wdata[CTL_ERASE];
      end
      if (wr_addr) addr_q <= reg_wdata;
      pg_err_q <= set_pg || (pg_err_q && !(wr_stat && reg_wdata[ST_PGERR]));
      wp_err_q <= set_wp || (wp_err_q && !(wr_stat && reg_wdata[ST_WPERR]));
      oob_q    <= user_oob;
      if (reg_re) begin
        case (reg_addr)
          RA_CTL:  reg_rdata <= {28'd0, locked, 1'b0, erase_en_q, prog_en_q};
          RA_STAT: reg_rdata <= {29'd0, wp_err_q, pg_err_q, busy};
          RA_ADDR: reg_rdata <= addr_q;
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  assign mem_rdata = oob_q ? 16'h0000 : arr_rdata;
endmodule

// File: rtl/nvm_pe_ctrl_chk.sv
module nvm_pe_ctrl_chk
  import nvm_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        reg_we,
  input logic        locked,
  input logic        busy,
  input logic        prog_en,
  input logic        erase_en,
  input logic        arr_we,
  input logic        set_pg,
  input logic        pg_err,
  input logic        wp_err
);
  // R2
  unlock_needs_key_b_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(reg_we && reg_addr == RA_KEY && reg_wdata == UNLOCK_KEY_B));

  // R4
  locked_no_enables_chk: assert property (@(posedge clk) disable iff (rst)
    locked |-> (!prog_en && !erase_en));

  // R4
  no_start_when_locked_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(locked));

  // R6
  array_write_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  // R11
  pg_err_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == RA_STAT && reg_wdata[ST_PGERR] && !set_pg) |=> !pg_err);

  // R9
  wp_err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wp_err) |-> !busy);
endmodule

bind nvm_pe_ctrl nvm_pe_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
  .locked(locked), .busy(busy), .prog_en(prog_en_q), .erase_en(erase_en_q),
  .arr_we(arr_we), .set_pg(set_pg), .pg_err(pg_err_q), .wp_err(wp_err_q)
);

// File: tb/nvm_pe_ctrl_tb.sv
module nvm_pe_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0800_0000;
  localparam int NPG = 4;
  localparam int ECYC = 600;
  localparam int PCYC = 6;
  localparam logic [31:0] KA = 32'h4567_0123;
  localparam logic [31:0] KB = 32'hCDEF_89AB;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [31:0] reg_rdata;
  logic [31:0] mem_addr = '0;
  logic [15:0] mem_wdata = '0;
  logic        mem_we = 1'b0;
  logic [15:0] mem_rdata;
  logic [NPG-1:0] wp_mask = '0;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_pe_ctrl #(.BASE_ADDR(BASE), .PAGE_BYTES(1024), .NUM_PAGES(NPG),
                .ERASE_CYC(ECYC), .PROG_CYC(PCYC)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .wp_mask(wp_mask)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_re = 1'b1;
    @(posedge clk); @(negedge clk); reg_re = 1'b0; d = reg_rdata;
  endtask

  task automatic mem_wr(input logic [31:0] a, input logic [15:0] d);
    @(negedge clk); mem_addr = a; mem_wdata = d; mem_we = 1'b1;
    @(posedge clk); @(negedge clk); mem_we = 1'b0;
  endtask

  task automatic mem_rd(input logic [31:0] a, output logic [15:0] d);
    @(negedge clk); mem_addr = a;
    @(posedge clk); @(negedge clk); d = mem_rdata;
  endtask

  // counts status reads that show busy, starting right after an accepted request
  task automatic busy_len(output int n);
    n = 0;
    reg_addr = 2'd2; reg_re = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); @(negedge clk);
      if (reg_rdata[0]) n++; else break;
    end
    reg_re = 1'b0;
  endtask

  task automatic unlock();
    reg_wr(2'd0, KA); reg_wr(2'd0, KB);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_rd(2'd1, d); chk("R1 ctl after reset", d, 32'h8);
    reg_rd(2'd2, d); chk("R1 status after reset", d, 32'h0);
  endtask

  task automatic t_locked_ignored();
    logic [31:0] d;
    reg_wr(2'd3, BASE);
    reg_wr(2'd1, 32'h7);
    reg_rd(2'd1, d); chk("R4 ctl bits while locked", d, 32'h8);
    reg_rd(2'd2, d); chk("R4 no busy while locked", d, 32'h0);
  endtask

  task automatic t_bad_key();
    logic [31:0] d;
    reg_wr(2'd0, KB);
    unlock();
    reg_rd(2'd1, d); chk("R3 stays locked after bad key", d, 32'h8);
  endtask

  task automatic t_unlock();
    logic [31:0] d;
    unlock();
    reg_rd(2'd1, d); chk("R2 unlocked ctl", d, 32'h0);
  endtask

  task automatic t_no_prog_en();
    logic [15:0] h;
    mem_wr(BASE + 32'h10, 16'h9999);
    mem_rd(BASE + 32'h10, h); chk("R13 write without program-enable", {16'd0, h}, 32'hFFFF);
  endtask

  task automatic t_program();
    logic [15:0] h; int n;
    reg_wr(2'd1, 32'h1);
    mem_wr(BASE + 32'h10, 16'h1234);
    busy_len(n); chk("R7 program busy cycles", n, PCYC);
    mem_rd(BASE + 32'h10, h); chk("R7 programmed value", {16'd0, h}, 32'h1234);
  endtask

  task automatic t_reprogram_w1c();
    logic [31:0] d; logic [15:0] h;
    mem_wr(BASE + 32'h10, 16'hABCD);
    repeat (PCYC + 2) @(negedge clk);
    mem_rd(BASE + 32'h10, h); chk("R8 dirty halfword unchanged", {16'd0, h}, 32'h1234);
    reg_rd(2'd2, d); chk("R8 program error flag", d, 32'h2);
    reg_wr(2'd2, 32'h0);
    reg_rd(2'd2, d); chk("R11 writing 0 keeps flag", d, 32'h2);
    reg_wr(2'd2, 32'h2);
    reg_rd(2'd2, d); chk("R11 writing 1 clears flag", d, 32'h0);
  endtask

  task automatic t_odd();
    logic [31:0] d; logic [15:0] h;
    mem_wr(BASE + 32'h21, 16'h4242);
    reg_rd(2'd2, d); chk("R10 odd address error", d, 32'h2);
    mem_rd(BASE + 32'h20, h); chk("R10 array unchanged", {16'd0, h}, 32'hFFFF);
    reg_wr(2'd2, 32'h2);
  endtask

  task automatic t_protect();
    logic [31:0] d; logic [15:0] h;
    wp_mask = 4'b1000;
    mem_wr(BASE + 32'hC00, 16'h5A5A);
    reg_rd(2'd2, d); chk("R9 protected program flag, no busy", d, 32'h4);
    mem_rd(BASE + 32'hC00, h); chk("R9 protected page unchanged", {16'd0, h}, 32'hFFFF);
    reg_wr(2'd2, 32'h4);
    reg_rd(2'd2, d); chk("R11 protection flag cleared", d, 32'h0);
    mem_wr(BASE + 32'h1000, 16'h5A5A);
    reg_rd(2'd2, d); chk("R9 out-of-window program", d, 32'h4);
    reg_wr(2'd2, 32'h4);
    reg_wr(2'd1, 32'h2);
    reg_wr(2'd3, BASE + 32'hC10);
    reg_wr(2'd1, 32'h6);
    reg_rd(2'd2, d); chk("R9 protected erase refused", d, 32'h4);
    reg_wr(2'd2, 32'h4);
    wp_mask = '0;
  endtask

  task automatic t_erase();
    logic [15:0] h; int n;
    reg_wr(2'd1, 32'h1);
    mem_wr(BASE + 32'h400, 16'h5555); repeat (PCYC + 1) @(negedge clk);
    mem_wr(BASE + 32'h7FE, 16'h6666); repeat (PCYC + 1) @(negedge clk);
    mem_wr(BASE + 32'h800, 16'h7777); repeat (PCYC + 1) @(negedge clk);
    mem_rd(BASE + 32'h7FE, h); chk("R7 last halfword of page 1", {16'd0, h}, 32'h6666);
    reg_wr(2'd1, 32'h2);
    reg_wr(2'd3, BASE + 32'h5F2);
    reg_wr(2'd1, 32'h6);
    busy_len(n); chk("R6 erase busy cycles", n, ECYC);
    mem_rd(BASE + 32'h400, h); chk("R6 page start erased", {16'd0, h}, 32'hFFFF);
    mem_rd(BASE + 32'h7FE, h); chk("R6 page end erased", {16'd0, h}, 32'hFFFF);
    mem_rd(BASE + 32'h800, h); chk("R6 next page kept", {16'd0, h}, 32'h7777);
    mem_rd(BASE + 32'h10, h); chk("R6 previous page kept", {16'd0, h}, 32'h1234);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d; logic [15:0] h;
    reg_wr(2'd1, 32'h1);
    mem_wr(BASE + 32'h900, 16'h1111);
    mem_wr(BASE + 32'h902, 16'h2222);
    reg_wr(2'd1, 32'h8);
    repeat (PCYC + 2) @(negedge clk);
    reg_rd(2'd1, d); chk("R12 lock write during busy ignored", d, 32'h1);
    mem_rd(BASE + 32'h902, h); chk("R12 program during busy ignored", {16'd0, h}, 32'hFFFF);
    mem_rd(BASE + 32'h900, h); chk("R12 first program landed", {16'd0, h}, 32'h1111);
  endtask

  task automatic t_relock();
    logic [31:0] d; logic [15:0] h;
    reg_wr(2'd1, 32'h8);
    reg_rd(2'd1, d); chk("R5 relock clears enables", d, 32'h8);
    mem_wr(BASE + 32'h904, 16'h3333);
    mem_rd(BASE + 32'h904, h); chk("R5 no program after relock", {16'd0, h}, 32'hFFFF);
    reg_wr(2'd1, 32'h1);
    reg_rd(2'd1, d); chk("R5 control still locked", d, 32'h8);
    unlock();
    reg_rd(2'd1, d); chk("R5 fresh keys unlock again", d, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_locked_ignored();
    t_bad_key();
    do_reset();
    t_unlock();
    t_no_prog_en();
    t_program();
    t_reprogram_w1c();
    t_odd();
    t_protect();
    t_erase();
    t_busy_ignore();
    t_relock();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule